// File: doc/BRIEF.md
# Paged program memory window decoder

This block sits between a 16-bit CPU address bus and a 20-bit program address space. A 6-bit page index register, written and read over the same bus, picks one of 64 pages of 16 KB. The selected page appears in a fixed 16 KB window of the logical map. The block builds the extended address and decides whether each access is served on-chip or off-chip. It also drives two active-low chip-select pads: one for emulation of flash space and one for external space.

The split between on-chip and off-chip paged memory comes from a 2-bit integration switch. On-chip pages are always the highest-numbered ones. When expansion is disabled, both chip-select pads carry general-purpose port data and direction values instead of decoder outputs. Every decode output is combinational from the current bus inputs and the page register, so it is valid in the same bus cycle.

Logical map used by the decoder:
- 0x0000–0x03FF: register space.
- 0x0400–0x1FFF: external space.
- 0x2000–0x3FFF: RAM.
- 0x4000–0x7FFF and 0xC000–0xFFFF: fixed flash.
- 0x8000–0xBFFF: paged window.

Top module: `prog_page_decoder`

## Requirements
- R1: The page register resets to 0. A bus write (`bus_act`=1, `cpu_rw`=0) to address 0x0030 loads `cpu_wdata` at the next rising clock edge. A read (`cpu_rw`=1) of 0x0030 returns the page on `rd_data`. `rd_data` is 0 at any other time.
- R2: For addresses 0x8000–0xBFFF, `ext_addr` equals the page index concatenated with `cpu_addr[13:0]`.
- R3: For any address outside the window, `ext_addr` equals 4'hF concatenated with `cpu_addr`.
- R4: A window access is internal (`is_ext`=0) when page ≥ 64 − 8·2^`cfg_sw`. The switch values map to on-chip space as follows: 00 → 8 pages, 01 → 16 pages, 10 → 32 pages, 11 → all 64 pages. Any lower page is external (`is_ext`=1).
- R5: Addresses 0x0400–0x1FFF are external. RAM, fixed flash and implemented register space are internal.
- R6: `ecs_pad` is low only when all of these hold: `expand_en`=1, `emul_mode`=1, `bus_act`=1, and the address is fixed flash or a window address on an internal page.
- R7: `xcs_pad` is low only when all of these hold: `expand_en`=1, `bus_act`=1, the access is external, and `ecs_pad` is inactive. The two selects are never low together.
- R8: Addresses 0x0032 and 0x0033 hold the port data and direction registers. When `emul_mode` and `expand_en` are both 1, these registers are removed from the map: `is_ext`=1, but `xcs_pad` stays high. In every other case they are internal.
- R9: When `expand_en`=0, `{ecs_pad,xcs_pad}` equals `gpio_dat` and `pad_oe` equals `gpio_dir`. Bit 1 is the emulation-select pin and bit 0 is the external-select pin. When `expand_en`=1, `pad_oe` is 2'b11.
- R10: Unimplemented locations in register space (for example 0x0000 and 0x03FF) are internal and never assert `xcs_pad`.
- R11: A read, or a write to any address other than 0x0030, leaves the page register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_act | input | 1 | Bus cycle in progress |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | 16 | CPU logical address |
| cpu_wdata | input | 6 | Write data for the page register |
| emul_mode | input | 1 | Emulation mode active |
| expand_en | input | 1 | Expansion enable; when 0, pads are general-purpose |
| cfg_sw | input | 2 | Integration switch selecting on-chip paged size |
| gpio_dat | input | 2 | Port data for the two pads when expansion is off |
| gpio_dir | input | 2 | Port direction for the two pads when expansion is off |
| ext_addr | output | 20 | Extended program address |
| is_ext | output | 1 | Access is off-chip |
| ecs_pad | output | 1 | Emulation chip select pad, active low |
| xcs_pad | output | 1 | External chip select pad, active low |
| pad_oe | output | 2 | Output enables for the two pads |
| rd_data | output | 6 | Page register read data |

## Verification
The bench probes the page threshold one page on each side of the boundary for all four switch values, including the value where every page is on-chip. An off-by-one compare would flip `is_ext` on exactly one of those pages. It checks the edges of the external region (0x0400, 0x1FFF) against RAM and register space. A wrong range would assert `xcs_pad` on internal memory, or on unimplemented registers. It also covers the removed port registers, which must read as external yet keep `xcs_pad` high, and the window with an off-chip page in emulation. Both must never assert the two selects together. Finally, it drives `expand_en` low during an external access to confirm that the pads follow the port values rather than the decoder.

// File: rtl/ppd_pkg.sv
package ppd_pkg;
    localparam int ADDR_W     = 16;
    localparam int PAGE_W     = 6;
    localparam int OFF_W      = 14;
    localparam int XADDR_W    = PAGE_W + OFF_W;
    localparam int HI_W       = XADDR_W - ADDR_W;
    localparam int BASE_PAGES = 8;

    localparam logic [ADDR_W-1:0] PAGE_REG_A = 16'h0030;
    localparam logic [ADDR_W-1:0] PORT_DAT_A = 16'h0032;
    localparam logic [ADDR_W-1:0] PORT_DIR_A = 16'h0033;
    localparam logic [ADDR_W-1:0] REG_END_A  = 16'h03FF;
    localparam logic [HI_W-1:0]   OUT_WIN_HI = '1;

    typedef enum logic [2:0] {
        RG_REG,
        RG_EXTIO,
        RG_RAM,
        RG_FLASH,
        RG_WINDOW
    } region_t;
endpackage

// File: rtl/ppd_page_reg.sv
module ppd_page_reg
    import ppd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_act,
    input  logic              cpu_rw,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [PAGE_W-1:0] cpu_wdata,
    output logic [PAGE_W-1:0] page_q,
    output logic [PAGE_W-1:0] rd_data
);
    logic hit;

    assign hit = bus_act && (cpu_addr == PAGE_REG_A);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (hit && !cpu_rw) begin
            page_q <= cpu_wdata;
        end
    end

    always_comb begin
        rd_data = '0;
        if (hit && cpu_rw) begin
            rd_data = page_q;
        end
    end
endmodule

// File: rtl/ppd_region_decode.sv
module ppd_region_decode
    import ppd_pkg::*;
(
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [PAGE_W-1:0]  page_q,
    input  logic [1:0]         cfg_sw,
    input  logic               emul_mode,
    input  logic               expand_en,
    output region_t            region,
    output logic               win_int,
    output logic               removed,
    output logic [XADDR_W-1:0] ext_addr
);
    localparam logic [PAGE_W:0] ALL_PAGES = 1 << PAGE_W;
    localparam logic [PAGE_W:0] BASE_CNT  = (PAGE_W+1)'(BASE_PAGES);

    logic [PAGE_W:0] onchip_cnt;
    logic [PAGE_W:0] first_int;

    always_comb begin
        onchip_cnt = BASE_CNT << cfg_sw;
        first_int  = ALL_PAGES - onchip_cnt;
        win_int    = ({1'b0, page_q} >= first_int);
    end

    always_comb begin
        unique case (cpu_addr[ADDR_W-1:ADDR_W-2])
            2'b10:   region = RG_WINDOW;
            2'b01,
            2'b11:   region = RG_FLASH;
            default: begin
                if (cpu_addr[ADDR_W-3])
                    region = RG_RAM;
                else if (cpu_addr <= REG_END_A)
                    region = RG_REG;
                else
                    region = RG_EXTIO;
            end
        endcase
    end

    always_comb begin
        removed = emul_mode && expand_en && (region == RG_REG) &&
                  ((cpu_addr == PORT_DAT_A) || (cpu_addr == PORT_DIR_A));
    end

    always_comb begin
        if (region == RG_WINDOW)
            ext_addr = {page_q, cpu_addr[OFF_W-1:0]};
        else
            ext_addr = {OUT_WIN_HI, cpu_addr};
    end
endmodule

// File: rtl/ppd_select.sv
module ppd_select
    import ppd_pkg::*;
(
    input  region_t    region,
    input  logic       win_int,
    input  logic       removed,
    input  logic       bus_act,
    input  logic       emul_mode,
    input  logic       expand_en,
    input  logic [1:0] gpio_dat,
    input  logic [1:0] gpio_dir,
    output logic       is_ext,
    output logic       ecs_pad,
    output logic       xcs_pad,
    output logic [1:0] pad_oe
);
    logic in_flash;
    logic ecs_act;
    logic xcs_act;

    always_comb begin
        unique case (region)
            RG_EXTIO:  is_ext = 1'b1;
            RG_WINDOW: is_ext = !win_int;
            RG_REG:    is_ext = removed;
            default:   is_ext = 1'b0;
        endcase
        in_flash = (region == RG_FLASH) || ((region == RG_WINDOW) && win_int);
    end

    always_comb begin
        ecs_act = bus_act && emul_mode && expand_en && in_flash;
        xcs_act = bus_act && expand_en && !ecs_act && is_ext && !removed;
    end

    always_comb begin
        if (expand_en) begin
            ecs_pad = !ecs_act;
            xcs_pad = !xcs_act;
            pad_oe  = 2'b11;
        end else begin
            ecs_pad = gpio_dat[1];
            xcs_pad = gpio_dat[0];
            pad_oe  = gpio_dir;
        end
    end
endmodule

// File: rtl/prog_page_decoder.sv
module prog_page_decoder
    import ppd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_act,
    input  logic               cpu_rw,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [PAGE_W-1:0]  cpu_wdata,
    input  logic               emul_mode,
    input  logic               expand_en,
    input  logic [1:0]         cfg_sw,
    input  logic [1:0]         gpio_dat,
    input  logic [1:0]         gpio_dir,
    output logic [XADDR_W-1:0] ext_addr,
    output logic               is_ext,
    output logic               ecs_pad,
    output logic               xcs_pad,
    output logic [1:0]         pad_oe,
    output logic [PAGE_W-1:0]  rd_data
);
    logic [PAGE_W-1:0] page_q;
    region_t           region;
    logic              win_int;
    logic              removed;

    ppd_page_reg u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_act   (bus_act),
        .cpu_rw    (cpu_rw),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .page_q    (page_q),
        .rd_data   (rd_data)
    );

    ppd_region_decode u_dec (
        .cpu_addr  (cpu_addr),
        .page_q    (page_q),
        .cfg_sw    (cfg_sw),
        .emul_mode (emul_mode),
        .expand_en (expand_en),
        .region    (region),
        .win_int   (win_int),
        .removed   (removed),
        .ext_addr  (ext_addr)
    );

    ppd_select u_sel (
        .region    (region),
        .win_int   (win_int),
        .removed   (removed),
        .bus_act   (bus_act),
        .emul_mode (emul_mode),
        .expand_en (expand_en),
        .gpio_dat  (gpio_dat),
        .gpio_dir  (gpio_dir),
        .is_ext    (is_ext),
        .ecs_pad   (ecs_pad),
        .xcs_pad   (xcs_pad),
        .pad_oe    (pad_oe)
    );
endmodule

// File: rtl/ppd_checker.sv
module ppd_checker
    import ppd_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               bus_act,
    input logic               cpu_rw,
    input logic [ADDR_W-1:0]  cpu_addr,
    input logic [PAGE_W-1:0]  cpu_wdata,
    input logic               emul_mode,
    input logic               expand_en,
    input logic [PAGE_W-1:0]  page_q,
    input logic [XADDR_W-1:0] ext_addr,
    input logic               is_ext,
    input logic               ecs_pad,
    input logic               xcs_pad,
    input logic [1:0]         pad_oe
);
    logic page_wr;
    assign page_wr = bus_act && !cpu_rw && (cpu_addr == PAGE_REG_A);

    AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        page_wr |=> (page_q == $past(cpu_wdata)));                        // R1

    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !page_wr |=> $stable(page_q));                                    // R11

    AST_WIN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b10) |-> (ext_addr[XADDR_W-1:OFF_W] == page_q)); // R2

    AST_ECS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (expand_en && !ecs_pad) |-> (emul_mode && bus_act && !is_ext));   // R6

    AST_CS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        expand_en |-> (ecs_pad || xcs_pad));                              // R7

    AST_XCS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (expand_en && !xcs_pad) |-> (is_ext && bus_act));                 // R7

    AST_PAD_OE: assert property (@(posedge clk) disable iff (!rst_n)
        expand_en |-> (pad_oe == 2'b11));                                 // R9
endmodule

bind prog_page_decoder ppd_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_act   (bus_act),
    .cpu_rw    (cpu_rw),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .emul_mode (emul_mode),
    .expand_en (expand_en),
    .page_q    (page_q),
    .ext_addr  (ext_addr),
    .is_ext    (is_ext),
    .ecs_pad   (ecs_pad),
    .xcs_pad   (xcs_pad),
    .pad_oe    (pad_oe)
);

// File: tb/sim_prog_page_decoder.sv
module sim_prog_page_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_act = 1'b0;
    logic        cpu_rw = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [5:0]  cpu_wdata = '0;
    logic        emul_mode = 1'b0;
    logic        expand_en = 1'b0;
    logic [1:0]  cfg_sw = 2'b00;
    logic [1:0]  gpio_dat = 2'b11;
    logic [1:0]  gpio_dir = 2'b00;
    logic [19:0] ext_addr;
    logic        is_ext;
    logic        ecs_pad;
    logic        xcs_pad;
    logic [1:0]  pad_oe;
    logic [5:0]  rd_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    prog_page_decoder u0 (
        .clk(clk), .rst_n(rst_n), .bus_act(bus_act), .cpu_rw(cpu_rw),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .emul_mode(emul_mode),
        .expand_en(expand_en), .cfg_sw(cfg_sw), .gpio_dat(gpio_dat),
        .gpio_dir(gpio_dir), .ext_addr(ext_addr), .is_ext(is_ext),
        .ecs_pad(ecs_pad), .xcs_pad(xcs_pad), .pad_oe(pad_oe), .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic act, input logic rw, input logic [15:0] a);
        @(negedge clk);
        bus_act  = act;
        cpu_rw   = rw;
        cpu_addr = a;
        #1;
    endtask

    task automatic write_page(input logic [15:0] a, input logic [5:0] d);
        @(negedge clk);
        bus_act = 1'b1; cpu_rw = 1'b0; cpu_addr = a; cpu_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_act = 1'b0; cpu_rw = 1'b1;
    endtask

    task automatic read_page(input string tag, input logic [5:0] exp);
        drive(1'b1, 1'b1, 16'h0030);
        check(tag, 32'(rd_data), 32'(exp));
    endtask

    function automatic logic exp_ext_page(input logic [5:0] p, input logic [1:0] c);
        int n;
        n = 8 << c;
        return !(int'(p) >= 64 - n);
    endfunction

    task automatic t_reset();
        read_page("R1 reset page", 6'h00);
        drive(1'b0, 1'b1, 16'h0030);
        check("R1 rd_data idle", 32'(rd_data), 0);
        drive(1'b1, 1'b1, 16'h8000);
        check("R2 reset window addr", 32'(ext_addr), 32'h00000);
    endtask

    task automatic t_page_rw();
        write_page(16'h0030, 6'h25);
        read_page("R1 readback", 6'h25);
        write_page(16'h0031, 6'h11);
        read_page("R11 other addr write", 6'h25);
        drive(1'b1, 1'b1, 16'h0030);
        drive(1'b1, 1'b1, 16'h0030);
        read_page("R11 read no change", 6'h25);
        drive(1'b1, 1'b1, 16'h0031);
        check("R1 rd_data other addr", 32'(rd_data), 0);
    endtask

    task automatic t_window_addr();
        drive(1'b1, 1'b1, 16'h9ABC);
        check("R2 window 9ABC", 32'(ext_addr), (32'h25 << 14) | 32'h1ABC);
        drive(1'b1, 1'b1, 16'hBFFF);
        check("R2 window BFFF", 32'(ext_addr), (32'h25 << 14) | 32'h3FFF);
        drive(1'b1, 1'b1, 16'h1234);
        check("R3 outside 1234", 32'(ext_addr), 32'hF1234);
        drive(1'b1, 1'b1, 16'hC000);
        check("R3 outside C000", 32'(ext_addr), 32'hFC000);
        drive(1'b1, 1'b1, 16'h7FFF);
        check("R3 outside 7FFF", 32'(ext_addr), 32'hF7FFF);
    endtask

    task automatic t_threshold();
        for (int c = 0; c < 4; c++) begin
            int lo;
            cfg_sw = 2'(c);
            lo = 64 - (8 << c);
            write_page(16'h0030, 6'(lo == 64 ? 63 : lo));
            drive(1'b1, 1'b1, 16'hA000);
            check("R4 first onchip page", 32'(is_ext), 32'(exp_ext_page(6'(lo), 2'(c))));
            check("R4 first onchip expect0", 32'(is_ext), 0);
            if (lo > 0) begin
                write_page(16'h0030, 6'(lo - 1));
                drive(1'b1, 1'b1, 16'hA000);
                check("R4 last offchip page", 32'(is_ext), 1);
            end else begin
                write_page(16'h0030, 6'h00);
                drive(1'b1, 1'b1, 16'hA000);
                check("R4 page0 all onchip", 32'(is_ext), 0);
            end
        end
        cfg_sw = 2'b00;
    endtask

    task automatic t_regions();
        emul_mode = 1'b0; expand_en = 1'b1;
        drive(1'b1, 1'b1, 16'h0400);
        check("R5 0400 ext", 32'(is_ext), 1);
        check("R7 0400 xcs", 32'(xcs_pad), 0);
        drive(1'b1, 1'b1, 16'h1FFF);
        check("R5 1FFF ext", 32'(is_ext), 1);
        drive(1'b1, 1'b1, 16'h2000);
        check("R5 ram int", 32'({is_ext, xcs_pad}), 32'b01);
        drive(1'b1, 1'b1, 16'h4000);
        check("R5 flash int", 32'({is_ext, xcs_pad, ecs_pad}), 32'b011);
        drive(1'b1, 1'b1, 16'h03FF);
        check("R10 unimpl 03FF", 32'({is_ext, xcs_pad}), 32'b01);
        drive(1'b1, 1'b1, 16'h0000);
        check("R10 unimpl 0000", 32'({is_ext, xcs_pad}), 32'b01);
    endtask

    task automatic t_chip_selects();
        emul_mode = 1'b1; expand_en = 1'b1; cfg_sw = 2'b00;
        drive(1'b1, 1'b1, 16'h4000);
        check("R6 fixed flash ecs", 32'({ecs_pad, xcs_pad}), 32'b01);
        write_page(16'h0030, 6'h3A);
        drive(1'b1, 1'b1, 16'h8000);
        check("R6 internal page ecs", 32'({ecs_pad, xcs_pad}), 32'b01);
        write_page(16'h0030, 6'h10);
        drive(1'b1, 1'b1, 16'h8000);
        check("R7 external page xcs", 32'({ecs_pad, xcs_pad}), 32'b10);
        drive(1'b0, 1'b1, 16'h8000);
        check("R6 idle bus no cs", 32'({ecs_pad, xcs_pad}), 32'b11);
        emul_mode = 1'b0;
        drive(1'b1, 1'b1, 16'hC100);
        check("R6 no emul no ecs", 32'({ecs_pad, xcs_pad}), 32'b11);
    endtask

    task automatic t_removed();
        emul_mode = 1'b1; expand_en = 1'b1;
        drive(1'b1, 1'b1, 16'h0032);
        check("R8 removed dat", 32'({is_ext, xcs_pad, ecs_pad}), 32'b111);
        drive(1'b1, 1'b0, 16'h0033);
        check("R8 removed dir", 32'({is_ext, xcs_pad, ecs_pad}), 32'b111);
        emul_mode = 1'b0;
        drive(1'b1, 1'b1, 16'h0032);
        check("R8 present dat", 32'({is_ext, xcs_pad}), 32'b01);
    endtask

    task automatic t_gpio();
        emul_mode = 1'b1; expand_en = 1'b0; gpio_dat = 2'b01; gpio_dir = 2'b10;
        drive(1'b1, 1'b1, 16'h0400);
        check("R9 gpio pads", 32'({ecs_pad, xcs_pad}), 32'b01);
        check("R9 gpio oe", 32'(pad_oe), 32'b10);
        gpio_dat = 2'b10;
        drive(1'b1, 1'b1, 16'h4000);
        check("R9 gpio pads flash", 32'({ecs_pad, xcs_pad}), 32'b10);
        expand_en = 1'b1;
        drive(1'b1, 1'b1, 16'h2000);
        check("R9 expand oe", 32'(pad_oe), 32'b11);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_page_rw();
        t_window_addr();
        t_threshold();
        t_regions();
        t_chip_selects();
        t_removed();
        t_gpio();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule